// File: doc/BRIEF.md
# Sampling Phase Tuning Window Engine

This block finds a good receive sampling delay for a high-speed memory-card data bus. It sweeps a delay line in coarse steps. At each step it asks an external transfer path for a known tuning block and compares every returned word against a pattern it computes itself. It keeps the longest run of consecutive passing steps and programs the delay line to the centre of that run.

Firmware starts a search with a one-cycle `start` pulse. It gives the current bus width and a clock band, and says whether the middle band needs tuning. The engine drives the delay line through its control outputs. Each delay write is a fixed three-step sequence followed by a bounded poll for calibration. The engine ends with a one-cycle `done` pulse, an error code, the chosen delay and the length of the winning run.

On failure the engine turns off the speed mode and the tuned-clock flag, so the bus falls back to the fixed sampling clock. On success the chosen delay is kept, and a `restore` pulse writes it to the delay line again, for example after a power-state change.

Top module: `tune_phase_engine`

## Requirements
- R1: After reset the following are all low or zero: `done`, `tuned`, `err_code`, `best_delay`, `best_len`, `dl_swt`, `dl_force`, `speed_mode`, `sclk_tuned` and `trial_req_valid`.
- R2: `bus_width` selects the bus width.
  - 2'b01 is a 4-bit bus: 16 words, and `trial_bytes` = 64.
  - 2'b10 is an 8-bit bus: 32 words, and `trial_bytes` = 128.
  - Any other value ends the search with `err_code` 1, `best_delay` 0 and `best_len` 0, and issues no trial. The width check comes before the clock-band check.
- R3: `clk_band` selects the clock band.
  - 2'b00 (up to 52 MHz) skips tuning.
  - 2'b01 (52 to 104 MHz) runs tuning only when `sdr50_needs_tune` is high, and skips it otherwise.
  - 2'b10 and 2'b11 (above 104 MHz) always run tuning.
  - A skip ends with `err_code` 0, `best_delay` 0, `best_len` 0, `tuned` low, and no trial.
- R4: A search issues exactly 32 trials at taps 0, 4, 8, …, 124 (while the tap is below 127). During each request, `dl_count` equals the tap and `dl_swt` is high. `trial_req_valid` stays high until `trial_req_ready` or `trial_timeout`.
- R5: A trial passes only when every received word k equals {4{b}}, where b = (37·k + K) mod 256. K is 8'hC3 for the 4-bit bus and 8'h5A for the 8-bit bus. A mismatch does not cut the word stream short.
- R6: The engine finds the longest run of consecutive passing trials and reports its length on `best_len`. A new run starts at the first trial or at any pass that follows a fail. Of two runs of equal length, the earlier one wins.
- R7: On success:
  - `best_delay` = 4·(run start + floor(run length / 2)).
  - `dl_swt` is cleared before that delay is written.
  - After `done`, `dl_count` equals `best_delay` and `dl_force` is high.
- R8: Each delay write takes these steps, in order:
  1. Load `dl_count` with `dl_calib` low.
  2. Raise `dl_force`.
  3. Raise `dl_calib`.
  4. Wait for `dl_calib_ack`, giving up after POLL_LIMIT (1000) cycles and continuing either way.
  5. Lower `dl_calib`.
- R9: A failed search sets `err_code` 2 if a trial times out, or 3 if no trial passes. It also sets `best_delay` and `best_len` to 0 and drives low `speed_mode`, `sclk_tuned`, `dl_force` and `dl_swt`.
- R10: `done` is high for exactly one cycle. `best_delay`, `best_len` and `err_code` change only in the cycle in which `done` is high.
- R11: A successful search sets `tuned` and stores the delay. While `tuned` is high, a `restore` pulse in idle rewrites the stored delay through the R8 sequence without pulsing `done`. While `tuned` is low, `restore` has no effect.
- R12: When tuning runs, `speed_mode` becomes 3'd2 for band 2'b01 and 3'd3 for the higher band, and it stays set after success. `sclk_tuned` goes high on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a search |
| restore | input | 1 | One-cycle pulse that rewrites the stored delay |
| bus_width | input | 2 | Data bus width code |
| clk_band | input | 2 | Bus clock band code |
| sdr50_needs_tune | input | 1 | Middle band requires tuning |
| trial_req_valid | output | 1 | Trial transfer request |
| trial_req_ready | input | 1 | Transfer path accepts the request |
| trial_bytes | output | 8 | Size of the tuning block in bytes |
| trial_word_valid | input | 1 | Received word strobe |
| trial_word | input | 32 | Received word |
| trial_timeout | input | 1 | Trial did not complete |
| dl_count | output | 7 | Delay-line tap setting |
| dl_force | output | 1 | Delay-line force-value control |
| dl_calib | output | 1 | Delay-line calibrate request |
| dl_swt | output | 1 | Software tuning enable |
| dl_calib_ack | input | 1 | Calibrate read-back |
| speed_mode | output | 3 | Bus speed-mode field |
| sclk_tuned | output | 1 | Tuned sampling clock in use |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 width, 2 timeout, 3 no pass |
| best_delay | output | 7 | Programmed delay |
| best_len | output | 6 | Length of the winning run |
| tuned | output | 1 | A tuned delay is stored |

## Verification
The properties assume the transfer path raises `trial_req_ready` and `trial_timeout` only while a request or its word stream is pending. They also assume it never sends more words than `trial_bytes` announces, that `start` arrives only while the engine is idle, and that `dl_calib_ack` follows `dl_calib` rather than running ahead of it. The bench responder keeps to these rules. It answers each request one cycle after it appears and then sends exactly the announced number of words, one per cycle, or a single timeout. It mirrors `dl_calib` onto the acknowledge one half-cycle later, or holds the acknowledge low in the case that exercises the poll limit. Start pulses are issued only after the previous `done`.

// File: rtl/tune_pkg.sv
package tune_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_WIDTH   = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_NOPASS  = 2'd3
    } tune_err_e;

    localparam logic [1:0] BW_NARROW = 2'b01;
    localparam logic [1:0] BW_WIDE   = 2'b10;

    localparam logic [2:0] MODE_OFF  = 3'd0;
    localparam logic [2:0] MODE_MID  = 3'd2;
    localparam logic [2:0] MODE_HIGH = 3'd3;

    typedef enum logic [3:0] {
        T_IDLE, T_SEQ, T_REQ, T_RECV, T_EVAL, T_PICK, T_ARM, T_PROG, T_RESTORE
    } tune_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_FORCE, SQ_CAL, SQ_POLL
    } dll_state_e;

    typedef struct packed {
        logic       wide;
        logic [2:0] mode;
    } tune_cfg_t;

    // Expected content of word k of the tuning block.
    function automatic logic [WORD_W-1:0] ref_word(input logic wide, input logic [7:0] idx);
        logic [7:0] b;
        b = 8'(int'(idx) * 37) + (wide ? 8'h5A : 8'hC3);
        return {4{b}};
    endfunction

endpackage

// File: rtl/tune_dll_seq.sv
module tune_dll_seq
    import tune_pkg::*;
#(
    parameter int TAP_W      = 7,
    parameter int POLL_LIMIT = 1000,
    localparam int POLL_W    = $clog2(POLL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [TAP_W-1:0] tap,
    input  logic             calib_ack,
    input  logic             drop_force,
    output logic [TAP_W-1:0] count,
    output logic             frc,
    output logic             calib,
    output logic             done
);

    dll_state_e        st;
    logic [POLL_W-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            count <= '0;
            frc   <= 1'b0;
            calib <= 1'b0;
            done  <= 1'b0;
            polls <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: if (go) begin
                    count <= tap;
                    calib <= 1'b0;
                    st    <= SQ_FORCE;
                end
                SQ_FORCE: begin
                    frc <= 1'b1;
                    st  <= SQ_CAL;
                end
                SQ_CAL: begin
                    calib <= 1'b1;
                    polls <= '0;
                    st    <= SQ_POLL;
                end
                SQ_POLL: begin
                    if (calib_ack || polls == POLL_W'(POLL_LIMIT - 1)) begin
                        calib <= 1'b0;
                        done  <= 1'b1;
                        st    <= SQ_IDLE;
                    end else begin
                        polls <= polls + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
            if (drop_force) frc <= 1'b0;
        end
    end

endmodule

// File: rtl/tune_word_cmp.sv
module tune_word_cmp
    import tune_pkg::*;
#(
    parameter int WCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wide,
    input  logic [WCNT_W-1:0] n_words,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              mismatch,
    output logic              got_all
);

    logic [WCNT_W-1:0] cnt;

    assign got_all = (cnt == n_words);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt      <= '0;
            mismatch <= 1'b0;
        end else if (word_valid && !got_all) begin
            if (word != ref_word(wide, 8'(cnt))) mismatch <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tune_run_track.sv
module tune_run_track #(
    parameter int IDX_W = 5,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             eval,
    input  logic             pass,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] best_start,
    output logic [LEN_W-1:0] best_len
);

    logic             prev_pass;
    logic [IDX_W-1:0] cur_start;
    logic [LEN_W-1:0] cur_len;
    logic [IDX_W-1:0] n_start;
    logic [LEN_W-1:0] n_len;

    always_comb begin
        if (prev_pass) begin
            n_start = cur_start;
            n_len   = cur_len + 1'b1;
        end else begin
            n_start = idx;
            n_len   = LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_pass  <= 1'b0;
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (eval) begin
            if (pass) begin
                prev_pass <= 1'b1;
                cur_start <= n_start;
                cur_len   <= n_len;
                if (n_len > best_len) begin
                    best_start <= n_start;
                    best_len   <= n_len;
                end
            end else begin
                prev_pass <= 1'b0;
                cur_len   <= '0;
            end
        end
    end

endmodule

// File: rtl/tune_phase_engine.sv
module tune_phase_engine
    import tune_pkg::*;
#(
    parameter int TAP_W        = 7,
    parameter int TAP_LIMIT    = 127,
    parameter int TAP_STEP     = 4,
    parameter int POLL_LIMIT   = 1000,
    parameter int WORDS_NARROW = 16,
    parameter int WORDS_WIDE   = 32,
    localparam int NTRIAL      = (TAP_LIMIT + TAP_STEP - 1) / TAP_STEP,
    localparam int IDX_W       = $clog2(NTRIAL),
    localparam int LEN_W       = $clog2(NTRIAL + 1),
    localparam int WCNT_W      = $clog2(WORDS_WIDE + 1),
    localparam int BYTES_W     = $clog2(4 * WORDS_WIDE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               restore,
    input  logic [1:0]         bus_width,
    input  logic [1:0]         clk_band,
    input  logic               sdr50_needs_tune,
    output logic               trial_req_valid,
    input  logic               trial_req_ready,
    output logic [BYTES_W-1:0] trial_bytes,
    input  logic               trial_word_valid,
    input  logic [WORD_W-1:0]  trial_word,
    input  logic               trial_timeout,
    output logic [TAP_W-1:0]   dl_count,
    output logic               dl_force,
    output logic               dl_calib,
    output logic               dl_swt,
    input  logic               dl_calib_ack,
    output logic [2:0]         speed_mode,
    output logic               sclk_tuned,
    output logic               done,
    output logic [1:0]         err_code,
    output logic [TAP_W-1:0]   best_delay,
    output logic [LEN_W-1:0]   best_len,
    output logic               tuned
);

    localparam logic [WCNT_W-1:0] NW_NARROW = WCNT_W'(WORDS_NARROW);
    localparam logic [WCNT_W-1:0] NW_WIDE   = WCNT_W'(WORDS_WIDE);

    tune_state_e       st;
    tune_cfg_t         cfg_q;
    logic [TAP_W:0]    tap_q;
    logic [TAP_W:0]    nxt_tap;
    logic [IDX_W-1:0]  trial_q;
    logic [TAP_W-1:0]  final_q;
    logic [TAP_W-1:0]  stored_q;
    logic [TAP_W-1:0]  pick_tap;

    logic              width_ok;
    logic              need_tune;
    logic              sweep_end;
    logic              seq_go;
    logic [TAP_W-1:0]  seq_tap;
    logic              seq_done;
    logic              fail_now;
    tune_err_e         fail_code;

    logic [WCNT_W-1:0] n_words;
    logic              cmp_mismatch;
    logic              cmp_all;
    logic [IDX_W-1:0]  trk_start;
    logic [LEN_W-1:0]  trk_len;

    assign width_ok  = (bus_width == BW_NARROW) || (bus_width == BW_WIDE);
    assign need_tune = clk_band[1] || (clk_band[0] && sdr50_needs_tune);
    assign nxt_tap   = tap_q + (TAP_W + 1)'(TAP_STEP);
    assign sweep_end = nxt_tap >= (TAP_W + 1)'(TAP_LIMIT);
    assign pick_tap  = TAP_W'(TAP_STEP * (int'(trk_start) + int'(trk_len >> 1)));

    assign n_words         = cfg_q.wide ? NW_WIDE : NW_NARROW;
    assign trial_bytes     = BYTES_W'(4 * int'(n_words));
    assign trial_req_valid = (st == T_REQ);

    always_comb begin
        fail_now  = 1'b0;
        fail_code = ERR_TIMEOUT;
        if ((st == T_REQ || st == T_RECV) && trial_timeout) begin
            fail_now = 1'b1;
        end else if (st == T_PICK && trk_len == '0) begin
            fail_now  = 1'b1;
            fail_code = ERR_NOPASS;
        end
    end

    always_comb begin
        seq_go  = 1'b0;
        seq_tap = tap_q[TAP_W-1:0];
        case (st)
            T_IDLE: begin
                if (start && width_ok && need_tune) begin
                    seq_go  = 1'b1;
                    seq_tap = '0;
                end else if (!start && restore && tuned) begin
                    seq_go  = 1'b1;
                    seq_tap = stored_q;
                end
            end
            T_EVAL: if (!sweep_end) begin
                seq_go  = 1'b1;
                seq_tap = nxt_tap[TAP_W-1:0];
            end
            T_ARM: begin
                seq_go  = 1'b1;
                seq_tap = final_q;
            end
            default: ;
        endcase
    end

    tune_dll_seq #(
        .TAP_W      (TAP_W),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (seq_go),
        .tap        (seq_tap),
        .calib_ack  (dl_calib_ack),
        .drop_force (fail_now),
        .count      (dl_count),
        .frc        (dl_force),
        .calib      (dl_calib),
        .done       (seq_done)
    );

    tune_word_cmp #(
        .WCNT_W (WCNT_W)
    ) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .clear      (st == T_REQ),
        .wide       (cfg_q.wide),
        .n_words    (n_words),
        .word_valid (trial_word_valid && st == T_RECV),
        .word       (trial_word),
        .mismatch   (cmp_mismatch),
        .got_all    (cmp_all)
    );

    tune_run_track #(
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) u_trk (
        .clk        (clk),
        .rst        (rst),
        .clear      (st == T_IDLE && start),
        .eval       (st == T_EVAL),
        .pass       (!cmp_mismatch),
        .idx        (trial_q),
        .best_start (trk_start),
        .best_len   (trk_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= T_IDLE;
            cfg_q      <= '0;
            tap_q      <= '0;
            trial_q    <= '0;
            final_q    <= '0;
            stored_q   <= '0;
            dl_swt     <= 1'b0;
            speed_mode <= MODE_OFF;
            sclk_tuned <= 1'b0;
            done       <= 1'b0;
            err_code   <= ERR_NONE;
            best_delay <= '0;
            best_len   <= '0;
            tuned      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: begin
                    if (start) begin
                        if (!width_ok) begin
                            done       <= 1'b1;
                            err_code   <= ERR_WIDTH;
                            best_delay <= '0;
                            best_len   <= '0;
                        end else if (!need_tune) begin
                            done       <= 1'b1;
                            err_code   <= ERR_NONE;
                            best_delay <= '0;
                            best_len   <= '0;
                            tuned      <= 1'b0;
                        end else begin
                            cfg_q.wide <= (bus_width == BW_WIDE);
                            cfg_q.mode <= clk_band[1] ? MODE_HIGH : MODE_MID;
                            speed_mode <= clk_band[1] ? MODE_HIGH : MODE_MID;
                            sclk_tuned <= 1'b0;
                            dl_swt     <= 1'b1;
                            tuned      <= 1'b0;
                            tap_q      <= '0;
                            trial_q    <= '0;
                            st         <= T_SEQ;
                        end
                    end else if (restore && tuned) begin
                        st <= T_RESTORE;
                    end
                end
                T_SEQ:  if (seq_done) st <= T_REQ;
                T_REQ:  if (trial_req_ready) st <= T_RECV;
                T_RECV: if (cmp_all) st <= T_EVAL;
                T_EVAL: begin
                    if (sweep_end) begin
                        st <= T_PICK;
                    end else begin
                        tap_q   <= nxt_tap;
                        trial_q <= trial_q + 1'b1;
                        st      <= T_SEQ;
                    end
                end
                T_PICK: begin
                    final_q <= pick_tap;
                    dl_swt  <= 1'b0;
                    st      <= T_ARM;
                end
                T_ARM: st <= T_PROG;
                T_PROG: if (seq_done) begin
                    done       <= 1'b1;
                    err_code   <= ERR_NONE;
                    best_delay <= final_q;
                    best_len   <= trk_len;
                    stored_q   <= final_q;
                    tuned      <= 1'b1;
                    sclk_tuned <= 1'b1;
                    speed_mode <= cfg_q.mode;
                    st         <= T_IDLE;
                end
                T_RESTORE: if (seq_done) st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
            if (fail_now) begin
                done       <= 1'b1;
                err_code   <= fail_code;
                best_delay <= '0;
                best_len   <= '0;
                speed_mode <= MODE_OFF;
                sclk_tuned <= 1'b0;
                dl_swt     <= 1'b0;
                st         <= T_IDLE;
            end
        end
    end

endmodule

// File: rtl/tune_phase_engine_chk.sv
module tune_phase_engine_chk #(
    parameter int TAP_W = 7,
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             tuned,
    input logic [1:0]       err_code,
    input logic [TAP_W-1:0] best_delay,
    input logic [LEN_W-1:0] best_len,
    input logic             trial_req_valid,
    input logic             trial_req_ready,
    input logic             trial_timeout,
    input logic [TAP_W-1:0] dl_count,
    input logic             dl_force,
    input logic             dl_calib,
    input logic             dl_swt,
    input logic [2:0]       speed_mode,
    input logic             sclk_tuned
);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_delay_stable_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(best_delay) |-> done);

    p_len_stable_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(best_len) |-> done);

    p_err_stable_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_code) |-> done);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (trial_req_valid && !trial_req_ready && !trial_timeout) |=> trial_req_valid);

    p_req_swt_r4: assert property (@(posedge clk) disable iff (rst)
        trial_req_valid |-> (dl_swt && dl_count[1:0] == 2'b00));

    p_calib_after_force_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(dl_calib) |-> dl_force);

    p_fallback_r9: assert property (@(posedge clk) disable iff (rst)
        (done && err_code[1]) |-> (speed_mode == 3'd0 && !dl_force && !dl_swt && !sclk_tuned));

    p_final_r7: assert property (@(posedge clk) disable iff (rst)
        (done && tuned) |-> (!dl_swt && dl_force && dl_count == best_delay));

endmodule

bind tune_phase_engine tune_phase_engine_chk u_chk (.*);

// File: tb/tune_phase_engine_test.sv
module tune_phase_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        restore = 1'b0;
    logic [1:0]  bus_width = 2'b01;
    logic [1:0]  clk_band = 2'b10;
    logic        sdr50_needs_tune = 1'b0;
    logic        trial_req_valid;
    logic        trial_req_ready = 1'b0;
    logic [7:0]  trial_bytes;
    logic        trial_word_valid = 1'b0;
    logic [31:0] trial_word = '0;
    logic        trial_timeout = 1'b0;
    logic [6:0]  dl_count;
    logic        dl_force;
    logic        dl_calib;
    logic        dl_swt;
    logic        dl_calib_ack = 1'b0;
    logic [2:0]  speed_mode;
    logic        sclk_tuned;
    logic        done;
    logic [1:0]  err_code;
    logic [6:0]  best_delay;
    logic [5:0]  best_len;
    logic        tuned;

    int checks = 0;
    int errors = 0;

    // responder controls
    logic [31:0] pass_mask = '0;
    int          timeout_at = -1;
    int          trial_no = 0;
    logic        ack_en = 1'b1;

    tune_phase_engine uut (
        .clk(clk), .rst(rst), .start(start), .restore(restore),
        .bus_width(bus_width), .clk_band(clk_band), .sdr50_needs_tune(sdr50_needs_tune),
        .trial_req_valid(trial_req_valid), .trial_req_ready(trial_req_ready),
        .trial_bytes(trial_bytes), .trial_word_valid(trial_word_valid),
        .trial_word(trial_word), .trial_timeout(trial_timeout),
        .dl_count(dl_count), .dl_force(dl_force), .dl_calib(dl_calib), .dl_swt(dl_swt),
        .dl_calib_ack(dl_calib_ack), .speed_mode(speed_mode), .sclk_tuned(sclk_tuned),
        .done(done), .err_code(err_code), .best_delay(best_delay), .best_len(best_len),
        .tuned(tuned)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [1:0]  w;
        logic [1:0]  b;
        logic        cap;
        logic [31:0] m;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'b01, 2'b10, 1'b0, 32'h0000FF00},
        '{2'b10, 2'b11, 1'b0, 32'h00001C1C},
        '{2'b10, 2'b10, 1'b0, 32'hFFFFFFFF},
        '{2'b01, 2'b10, 1'b0, 32'h80000000},
        '{2'b01, 2'b10, 1'b0, 32'h00000000},
        '{2'b10, 2'b01, 1'b1, 32'h000000F0},
        '{2'b01, 2'b01, 1'b0, 32'h0000FFFF},
        '{2'b10, 2'b00, 1'b1, 32'h0000FFFF},
        '{2'b00, 2'b10, 1'b1, 32'h0000FFFF},
        '{2'b11, 2'b00, 1'b0, 32'h0000FFFF},
        '{2'b01, 2'b10, 1'b0, 32'h00F00F0F},
        '{2'b10, 2'b11, 1'b0, 32'hF0FFF000}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic wide, input int k);
        logic [7:0] b;
        b = 8'((37 * k + (wide ? 32'h5A : 32'hC3)) % 256);
        return {4{b}};
    endfunction

    function automatic void best_run(input logic [31:0] m, output int s, output int l);
        int  cs = 0;
        int  cl = 0;
        bit  prev = 0;
        s = 0;
        l = 0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                if (!prev) begin cs = i; cl = 1; end
                else cl++;
                if (cl > l) begin l = cl; s = cs; end
                prev = 1;
            end else begin
                prev = 0;
            end
        end
    endfunction

    // calibrate acknowledge follows dl_calib half a cycle later
    initial begin : ack_model
        forever begin
            @(negedge clk);
            dl_calib_ack = ack_en ? dl_calib : 1'b0;
        end
    end

    // transfer-path responder
    initial begin : responder
        forever begin
            @(negedge clk);
            if (!rst && trial_req_valid) begin
                logic wide;
                int   nw;
                wide = (bus_width == 2'b10);
                nw   = wide ? 32 : 16;
                chk("R4", "tap at request", int'(dl_count), 4 * trial_no);
                chk("R4", "swt during sweep", int'(dl_swt), 1);
                chk("R2", "trial bytes", int'(trial_bytes), nw * 4);
                trial_req_ready = 1'b1;
                @(negedge clk);
                trial_req_ready = 1'b0;
                if (trial_no == timeout_at) begin
                    trial_timeout = 1'b1;
                    @(negedge clk);
                    trial_timeout = 1'b0;
                end else begin
                    for (int k = 0; k < nw; k++) begin
                        trial_word = exp_word(wide, k);
                        if (!pass_mask[trial_no] && k == (trial_no % 3) * 5)
                            trial_word = trial_word ^ 32'h0000_0100;
                        trial_word_valid = 1'b1;
                        @(negedge clk);
                    end
                    trial_word_valid = 1'b0;
                end
                trial_no++;
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual 0 expected 1 (done never seen)");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic run_tune(input logic [1:0] w, input logic [1:0] b, input logic cap,
                            input logic [31:0] m, input int to_at, output bit seen);
        bus_width        = w;
        clk_band         = b;
        sdr50_needs_tune = cap;
        pass_mask        = m;
        timeout_at       = to_at;
        trial_no         = 0;
        seen             = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R10", "done observed", int'(seen), 1);
    endtask

    task automatic check_hold;
        logic [6:0] d;
        logic [5:0] l;
        logic [1:0] e;
        d = best_delay; l = best_len; e = err_code;
        @(negedge clk);
        chk("R10", "done one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        chk("R10", "delay held", int'(best_delay), int'(d));
        chk("R10", "len held", int'(best_len), int'(l));
        chk("R10", "err held", int'(err_code), int'(e));
    endtask

    initial begin : main
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done", int'(done), 0);
        chk("R1", "tuned", int'(tuned), 0);
        chk("R1", "err", int'(err_code), 0);
        chk("R1", "delay", int'(best_delay), 0);
        chk("R1", "len", int'(best_len), 0);
        chk("R1", "swt", int'(dl_swt), 0);
        chk("R1", "force", int'(dl_force), 0);
        chk("R1", "mode", int'(speed_mode), 0);
        chk("R1", "sclk", int'(sclk_tuned), 0);
        chk("R1", "req", int'(trial_req_valid), 0);

        for (int v = 0; v < 12; v++) begin
            vec_t t;
            bit   wok;
            bit   runs;
            int   s;
            int   l;
            t    = VECS[v];
            wok  = (t.w == 2'b01) || (t.w == 2'b10);
            runs = t.b[1] || (t.b == 2'b01 && t.cap);
            best_run(t.m, s, l);
            run_tune(t.w, t.b, t.cap, t.m, -1, seen);
            if (!wok) begin
                chk("R2", "width error code", int'(err_code), 1);
                chk("R2", "no trials", trial_no, 0);
                chk("R2", "delay", int'(best_delay), 0);
            end else if (!runs) begin
                chk("R3", "skip code", int'(err_code), 0);
                chk("R3", "skip trials", trial_no, 0);
                chk("R3", "skip delay", int'(best_delay), 0);
                chk("R3", "skip len", int'(best_len), 0);
                chk("R3", "skip tuned", int'(tuned), 0);
            end else if (l == 0) begin
                chk("R9", "no-pass code", int'(err_code), 3);
                chk("R4", "trial count", trial_no, 32);
                chk("R9", "mode off", int'(speed_mode), 0);
                chk("R9", "sclk off", int'(sclk_tuned), 0);
                chk("R9", "force off", int'(dl_force), 0);
                chk("R9", "swt off", int'(dl_swt), 0);
                chk("R9", "delay", int'(best_delay), 0);
            end else begin
                chk("R5", "success code", int'(err_code), 0);
                chk("R4", "trial count", trial_no, 32);
                chk("R6", "run length", int'(best_len), l);
                chk("R7", "final delay", int'(best_delay), 4 * (s + l / 2));
                chk("R7", "dl_count final", int'(dl_count), 4 * (s + l / 2));
                chk("R7", "swt cleared", int'(dl_swt), 0);
                chk("R7", "force set", int'(dl_force), 1);
                chk("R11", "tuned", int'(tuned), 1);
                chk("R12", "mode", int'(speed_mode), t.b[1] ? 3 : 2);
                chk("R12", "sclk tuned", int'(sclk_tuned), 1);
            end
            check_hold();
        end

        // R8: acknowledge never comes, every write gives up after the poll limit
        ack_en = 1'b0;
        run_tune(2'b01, 2'b10, 1'b0, 32'h0000FF00, -1, seen);
        chk("R8", "poll limit code", int'(err_code), 0);
        chk("R8", "poll limit delay", int'(best_delay), 48);
        chk("R8", "calib lowered", int'(dl_calib), 0);
        ack_en = 1'b1;
        check_hold();

        // R11: restore reapplies the stored delay while tuned
        begin
            bit rose;
            rose = 0;
            @(negedge clk);
            restore = 1'b1;
            @(negedge clk);
            restore = 1'b0;
            for (int i = 0; i < 12; i++) begin
                if (done) chk("R11", "restore no done", 1, 0);
                if (dl_calib) begin
                    rose = 1;
                    chk("R11", "restore tap", int'(dl_count), 48);
                    chk("R8", "force before calib", int'(dl_force), 1);
                end
                @(negedge clk);
            end
            chk("R11", "restore calib pulse", int'(rose), 1);
        end

        // R9: timeout on trial 5
        run_tune(2'b10, 2'b11, 1'b0, 32'hFFFFFFFF, 5, seen);
        chk("R9", "timeout code", int'(err_code), 2);
        chk("R9", "timeout trials", trial_no, 6);
        chk("R9", "mode off", int'(speed_mode), 0);
        chk("R9", "sclk off", int'(sclk_tuned), 0);
        chk("R9", "force off", int'(dl_force), 0);
        chk("R9", "swt off", int'(dl_swt), 0);
        chk("R9", "delay", int'(best_delay), 0);
        chk("R11", "tuned cleared", int'(tuned), 0);
        check_hold();

        // R11: restore without a stored result has no effect
        begin
            bit moved;
            moved = 0;
            @(negedge clk);
            restore = 1'b1;
            @(negedge clk);
            restore = 1'b0;
            for (int i = 0; i < 20; i++) begin
                if (dl_calib || dl_force || done) moved = 1;
                @(negedge clk);
            end
            chk("R11", "restore ignored", int'(moved), 0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule